// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block connects a 16-entry byte-wide register map to a three-wire synchronous serial bus. The bus has an enable line (CE), a serial clock (SCLK) and one shared data line, which the block sees as a separate input and output with an output-enable. All bus inputs are sampled by the block's own system clock, so the serial clock must be slow compared to it. Each transaction starts when CE goes high and ends when CE goes low. The first byte carries the register index and the transfer direction. Any number of data bytes can follow. A transfer of one data byte is a single access, and a longer one is a burst through consecutive registers.

When CE rises, the block copies the live timekeeping bytes into a private snapshot. Reads of the timekeeping indices are served from that copy for the whole transaction, so a read burst returns one coherent time value while the counters keep running. Reads of the other indices come straight from the register map. Writes of every index are passed to the map, one strobe per complete byte.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset, io_oe_o, io_o and reg_we_o are all low.
- R2: The first byte after CE rises is the command byte, sent LSB first. Bits 3:0 are the register index and bit 7 is the direction (1 = write, 0 = read). Bits 6:4 have no effect.
- R3: In a write transaction, each complete data byte gives exactly one single-cycle reg_we_o pulse. During that pulse, reg_addr_o holds the current index and reg_wdata_o holds the byte. The data byte is sent LSB first.
- R4: After each data byte the index moves up by one, and it wraps from 15 to 0.
- R5: Read data is shifted out LSB first. Each bit appears on io_o after a falling SCLK edge and is valid at the next rising SCLK edge.
- R6: io_oe_o is high only during the data bytes of a read. It stays low during the command byte and during writes.
- R7: io_oe_o goes low within 6 system clocks after CE goes low.
- R8: At each CE rise, the NTIME live time bytes (index 0 to NTIME-1, byte i at live_time_i[8i+7:8i]) are copied into the snapshot. Reads of those indices return the copy, even if the live bytes change later in the same transaction.
- R9: If CE goes low partway through a data byte, that partial byte is discarded and no write strobe is issued.
- R10: Reads of indices NTIME and above return reg_rdata_i, sampled for the index on reg_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Transaction enable, active high |
| sclk_i | input | 1 | Serial clock from the master |
| io_i | input | 1 | Serial data line, input side |
| io_o | output | 1 | Serial data line, output value |
| io_oe_o | output | 1 | Output enable for the data line |
| live_time_i | input | NTIME*8 | Live timekeeping bytes |
| reg_addr_o | output | AW | Register index for read or write |
| reg_rdata_i | input | 8 | Read data from the register map |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |

## Verification
The coherence of the snapshot is hard to observe at the ports. It only shows when the live time changes between CE rising and the moment a byte is shifted out. The bench therefore replaces the live time bytes with their complement just after every CE rise. Any read of a time index that follows the live bus, and not the copy, then returns the wrong value. The partial-byte abort is reached by dropping CE after four data bits of a write. The bench then reads the same index back to show that the map was left untouched.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CMD   = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } phase_t;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 3;
  localparam int DIR_BIT = 7;
endpackage

// File: rtl/tws_rstsync.sv
module tws_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/tws_insync.sv
module tws_insync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/tws_frame.sv
module tws_frame
  import tws_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_lvl,
  input  logic                ce_rise,
  input  logic                sclk_rise,
  input  logic                din,
  output phase_t              phase_o,
  output logic [AW-1:0]       ptr_o,
  output logic [CNT_W-1:0]    bit_cnt_o,
  output logic                we_o,
  output logic [AW-1:0]       waddr_o,
  output logic [BYTE_W-1:0]   wdata_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_t              phase_q, phase_d;
  logic [AW-1:0]       ptr_q, ptr_d;
  logic [AW-1:0]       waddr_q, waddr_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-1:0]   rx_q, rx_d;
  logic [BYTE_W-1:0]   wdata_q, wdata_d;
  logic                we_q, we_d;
  logic [BYTE_W-1:0]   byte_w;
  logic                byte_end;

  assign byte_w   = {din, rx_q[BYTE_W-1:1]};
  assign byte_end = sclk_rise && (cnt_q == LAST_BIT);

  always_comb begin
    phase_d = phase_q;
    ptr_d   = ptr_q;
    waddr_d = waddr_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    if (!ce_lvl) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (ce_rise) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
    end else if (sclk_rise && phase_q != PH_IDLE) begin
      rx_d  = byte_w;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_BIT) begin
        unique case (phase_q)
          PH_CMD: begin
            ptr_d   = byte_w[AW-1:0];
            phase_d = byte_w[DIR_BIT] ? PH_WRITE : PH_READ;
          end
          PH_WRITE: begin
            we_d    = 1'b1;
            wdata_d = byte_w;
            waddr_d = ptr_q;
            ptr_d   = ptr_q + 1'b1;
          end
          PH_READ: begin
            ptr_d = ptr_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
      waddr_q <= '0;
      cnt_q   <= '0;
      rx_q    <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
      waddr_q <= waddr_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
    end
  end

  assign phase_o   = phase_q;
  assign ptr_o     = ptr_q;
  assign bit_cnt_o = cnt_q;
  assign we_o      = we_q;
  assign waddr_o   = waddr_q;
  assign wdata_o   = wdata_q;

  assert_we_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (phase_q == PH_WRITE));
  assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_WRITE || phase_q == PH_READ) && ce_lvl && !byte_end)
      |=> $stable(ptr_q));
endmodule

// File: rtl/tws_snap.sv
module tws_snap #(
  parameter int AW    = 4,
  parameter int NTIME = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  logic [NTIME*8-1:0] live_i,
  input  logic [AW-1:0]      idx_i,
  input  logic [7:0]         ext_i,
  output logic [7:0]         byte_o
);
  logic [NTIME*8-1:0] snap_q, snap_d;

  always_comb begin
    snap_d = snap_q;
    if (cap_i) snap_d = live_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  always_comb begin
    byte_o = ext_i;
    for (int i = 0; i < NTIME; i++) begin
      if (idx_i == AW'(i)) byte_o = snap_q[i*8 +: 8];
    end
  end

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(snap_q));
endmodule

// File: rtl/tws_iodrv.sv
module tws_iodrv
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_lvl,
  input  logic              sclk_fall,
  input  logic              rd_phase,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              io_o,
  output logic              oe_o
);
  logic              oe_q, oe_d;
  logic              out_q, out_d;
  logic [BYTE_W-1:0] sh_q, sh_d;

  always_comb begin
    oe_d  = oe_q;
    out_d = out_q;
    sh_d  = sh_q;
    if (!ce_lvl || !rd_phase) begin
      oe_d = 1'b0;
    end else if (sclk_fall) begin
      oe_d = 1'b1;
      if (bit_cnt == '0) begin
        out_d = byte_i[0];
        sh_d  = {1'b0, byte_i[BYTE_W-1:1]};
      end else begin
        out_d = sh_q[0];
        sh_d  = {1'b0, sh_q[BYTE_W-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      oe_q  <= oe_d;
      out_q <= out_d;
      sh_q  <= sh_d;
    end
  end

  assign io_o = out_q;
  assign oe_o = oe_q;

  assert_oe_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> rd_phase);
  assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_lvl |=> !oe_q);
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tws_pkg::*;
#(
  parameter int AW    = 4,
  parameter int NTIME = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_i,
  input  logic               sclk_i,
  input  logic               io_i,
  output logic               io_o,
  output logic               io_oe_o,
  input  logic [NTIME*8-1:0] live_time_i,
  output logic [AW-1:0]      reg_addr_o,
  input  logic [7:0]         reg_rdata_i,
  output logic               reg_we_o,
  output logic [7:0]         reg_wdata_o
);
  localparam int SIG_CE = 0;
  localparam int SIG_SCLK = 1;
  localparam int SIG_IO = 2;
  localparam int NSIG = 3;

  logic              rst_n_s;
  logic [NSIG-1:0]   lvl, rise, fall;
  phase_t            phase;
  logic [AW-1:0]     ptr, waddr;
  logic [CNT_W-1:0]  bit_cnt;
  logic              we;
  logic [7:0]        wdata, rd_byte;

  tws_rstsync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  tws_insync #(.W(NSIG)) u_sync (
    .clk(clk), .rst_n(rst_n_s),
    .raw_i({io_i, sclk_i, ce_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  tws_frame #(.AW(AW)) u_frame (
    .clk(clk), .rst_n(rst_n_s),
    .ce_lvl(lvl[SIG_CE]), .ce_rise(rise[SIG_CE]),
    .sclk_rise(rise[SIG_SCLK]), .din(lvl[SIG_IO]),
    .phase_o(phase), .ptr_o(ptr), .bit_cnt_o(bit_cnt),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
  );

  tws_snap #(.AW(AW), .NTIME(NTIME)) u_snap (
    .clk(clk), .rst_n(rst_n_s),
    .cap_i(rise[SIG_CE]), .live_i(live_time_i),
    .idx_i(ptr), .ext_i(reg_rdata_i), .byte_o(rd_byte)
  );

  tws_iodrv u_io (
    .clk(clk), .rst_n(rst_n_s),
    .ce_lvl(lvl[SIG_CE]), .sclk_fall(fall[SIG_SCLK]),
    .rd_phase(phase == PH_READ), .bit_cnt(bit_cnt),
    .byte_i(rd_byte), .io_o(io_o), .oe_o(io_oe_o)
  );

  assign reg_addr_o  = we ? waddr : ptr;
  assign reg_we_o    = we;
  assign reg_wdata_o = wdata;

  assert_no_oe_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase == PH_WRITE || phase == PH_CMD) |-> !io_oe_o);
endmodule

// File: tb/sim_tw_reg_slave.sv
module sim_tw_reg_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int NT    = 7;
  localparam int NVEC  = 8;

  // {dir, index, length, seed}
  localparam logic [16:0] VEC [0:NVEC-1] = '{
    {1'b1, 4'h8, 4'h1, 8'h5A},
    {1'b0, 4'h8, 4'h1, 8'h11},
    {1'b1, 4'hE, 4'h4, 8'hC3},
    {1'b0, 4'hE, 4'h4, 8'h22},
    {1'b0, 4'h0, 4'h7, 8'h3C},
    {1'b1, 4'h3, 4'h2, 8'h99},
    {1'b0, 4'h3, 4'h2, 8'h47},
    {1'b0, 4'hF, 4'h3, 8'h6B}
  };

  logic clk, rst_n, ce, sclk, io_in;
  logic io_out, io_oe;
  logic [NT*8-1:0] live;
  logic [3:0] raddr;
  logic [7:0] rdata, wdata;
  logic we;
  logic [7:0] map [0:15];
  logic [7:0] exp_map [0:15];
  int n_chk, n_fail, we_cnt;
  bit finished;

  tw_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .io_i(io_in),
    .io_o(io_out), .io_oe_o(io_oe), .live_time_i(live),
    .reg_addr_o(raddr), .reg_rdata_i(rdata), .reg_we_o(we), .reg_wdata_o(wdata)
  );

  assign rdata = map[raddr];

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) map[i] <= 8'hA0 + 8'(i);
      we_cnt <= 0;
    end else if (we) begin
      map[raddr] <= wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  function automatic logic [NT*8-1:0] pat(input logic [7:0] s);
    for (int i = 0; i < NT; i++) pat[i*8 +: 8] = s ^ 8'(i * 17);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCLK period: drive bit, sample output just before the rising edge
  task automatic bit_io(input logic b, output logic r, output logic oe);
    io_in = b;
    wait_clk(HALF);
    r  = io_out;
    oe = io_oe;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic xact(input logic [7:0] cmd, input int len, input logic [7:0] seed, input int abort_bits);
    logic [NT*8-1:0] snap;
    logic r, oe;
    logic [7:0] got, exp_b;
    logic [3:0] a;
    bit oe_bad;
    int we0;
    snap = pat(seed);
    live = snap;
    wait_clk(2);
    ce = 1'b1;
    wait_clk(HALF);
    live = ~snap;                 // live time moves on after CE rise
    we0 = we_cnt;
    oe_bad = 0;
    for (int k = 0; k < 8; k++) begin
      bit_io(cmd[k], r, oe);
      if (oe) oe_bad = 1;
    end
    chk(!oe_bad, "R6 oe low in command byte", 16'(oe_bad), 16'h0);
    for (int j = 0; j < len; j++) begin
      a = cmd[3:0] + 4'(j);
      if (cmd[7]) begin
        exp_b = seed + 8'(j * 7);
        oe_bad = 0;
        for (int k = 0; k < 8; k++) begin
          bit_io(exp_b[k], r, oe);
          if (oe) oe_bad = 1;
        end
        exp_map[a] = exp_b;
        chk(!oe_bad, "R6 oe low in write byte", 16'(oe_bad), 16'h0);
      end else begin
        exp_b = (a < NT) ? snap[a*8 +: 8] : exp_map[a];
        oe_bad = 0;
        for (int k = 0; k < 8; k++) begin
          bit_io(1'b0, r, oe);
          got[k] = r;
          if (!oe) oe_bad = 1;
        end
        chk(!oe_bad, "R6 oe high in read byte", 16'(oe_bad), 16'h0);
        if (a < NT) chk(got === exp_b, "R8 snapshot read", {8'(a), got}, {8'(a), exp_b});
        else        chk(got === exp_b, "R5 R10 map read LSB first", {8'(a), got}, {8'(a), exp_b});
      end
    end
    for (int k = 0; k < abort_bits; k++) bit_io(1'b1, r, oe);
    wait_clk(HALF);
    ce = 1'b0;
    wait_clk(6);
    chk(io_oe === 1'b0, "R7 oe released", 16'(io_oe), 16'h0);
    wait_clk(HALF);
    if (cmd[7]) begin
      chk(we_cnt - we0 == len, "R3 R9 strobe count", 16'(we_cnt - we0), 16'(len));
      for (int j = 0; j < len; j++) begin
        a = cmd[3:0] + 4'(j);
        chk(map[a] === exp_map[a], "R3 R4 written byte", {8'(a), map[a]}, {8'(a), exp_map[a]});
      end
    end
  endtask

  initial begin
    finished = 0;
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; ce = 1'b0; sclk = 1'b0; io_in = 1'b0; live = '0;
    for (int i = 0; i < 16; i++) exp_map[i] = 8'hA0 + 8'(i);
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(5);
    chk(io_oe === 1'b0, "R1 reset oe", 16'(io_oe), 16'h0);
    chk(io_out === 1'b0, "R1 reset io", 16'(io_out), 16'h0);
    chk(we === 1'b0, "R1 reset we", 16'(we), 16'h0);

    for (int v = 0; v < NVEC; v++) begin
      xact({VEC[v][16], 3'b000, VEC[v][15:12]}, int'(VEC[v][11:8]), VEC[v][7:0], 0);
    end

    // R9: CE drops after four bits of a write data byte at index 5
    xact(8'h85, 0, 8'h00, 4);
    xact(8'h05, 1, 8'h00, 0);      // index 5 is a time byte: snapshot
    xact(8'h0A, 1, 8'h10, 0);
    chk(map[10] === exp_map[10], "R9 map untouched", {8'd10, map[10]}, {8'd10, exp_map[10]});
    xact(8'h8A, 0, 8'h00, 5);
    chk(map[10] === exp_map[10], "R9 no partial write", {8'd10, map[10]}, {8'd10, exp_map[10]});

    // R2: bits 6:4 of the command byte are ignored
    xact(8'hF9, 1, 8'h77, 0);     // write index 9
    xact(8'h79, 1, 8'h00, 0);     // read index 9
    chk(map[9] === 8'h77, "R2 write with bits 6:4 set", {8'd9, map[9]}, {8'd9, 8'h77});

    // R4: burst read wraps through 15 to 0 on map bytes and snapshot bytes
    xact(8'h0D, 5, 8'h5C, 0);

    finish_run();
  end
endmodule